// File: doc/BRIEF.md
# Third-Order Noise-Shaping Dither Modulator

This block converts a small fractional control word into a stream of short signed dither steps. Over time, the steps average to the word divided by the accumulator modulus. The quantisation error is pushed toward high frequencies. Three equal-width accumulators sit in a chain: the first adds the input word, the second adds the first one's new remainder, and the third adds the second one's new remainder. The carry bits leaving the three stages are recombined with one-cycle and two-cycle delay-and-difference terms into a single small signed code. That code drives a handful of switched cells in an oscillator.

A two-bit run-time order select picks the noise-shaping order:

| Code | Name | Output |
|---|---|---|
| 0 | `ORD_OFF` | Zero at all times; dithering is disabled |
| 1 | `ORD_ONE` | First-stage carry only |
| 2 | `ORD_TWO` | Adds the second-stage difference term |
| 3 | `ORD_THREE` | Adds the third-stage double-difference term |

The accumulators and carry delay lines keep running in every order. Only the contributions to the output are gated, so a change of order takes effect on the next output without a restart.

There is no sequencing state machine: the block's only "states" are the four orders above. Transitions between them are immediate, on any clock edge, and are driven only by `order_sel`.

Top module: `mash_dither`

## Requirements
- R1: While `rst_n` is low, and after its release until the first rising clock edge, `dither_out` is 0 and all accumulators and carry delays are cleared.
- R2: With order code 1, each rising edge adds `frac_word` to stage one modulo 2^ACC_W. `dither_out` after that edge equals that addition's carry (0 or 1). With `frac_word` = 16 from reset, the outputs after successive edges are 0, 1, 0, 1, and so on.
- R3: With order code 0, `dither_out` is 0 after the next rising edge, whatever `frac_word` and the accumulator contents are.
- R4: `dither_out` is a 4-bit two's-complement value that always lies in -3 to +4.
- R5: With constant `frac_word` F held from reset for 32·k edges, the sum of the outputs obeys these bounds: for order 1 it equals k·F exactly; for order 2 it lies in k·F to k·F+1; for order 3 it lies in k·F-1 to k·F+2.
- R6: With `frac_word` = 0 from reset, `dither_out` stays 0 in every order.
- R7: With order code 2, `dither_out` after the next edge lies in -1 to +2.
- R8: The output after each edge is formed from the carries c1, c2 and c3 of that edge, plus the previous c2 (p2), the previous c3 (p3) and the one before that (q3). The value is c1, plus (c2-p2) for order ≥ 2, plus (c3-2·p3+q3) for order 3.
- R9: Changes of `frac_word` or `order_sel` are taken at the next rising edge and are reflected in `dither_out` right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| frac_word | input | ACC_W (5) | Fractional control word, unsigned |
| order_sel | input | 2 | Noise-shaping order: 0 off, 1, 2 or 3 |
| dither_out | output | DITH_W (4) | Signed dither step, two's complement |

## Verification
The bench builds the block with its defaults: 5-bit accumulators and a 4-bit output. At those defaults the accumulator wraps every 32 edges, so whole averaging windows of 32·k cycles fit in short runs. Every order, and the input extremes 0, 1, 16 and 31, can then be compared cycle by cycle against an integer model written from R8. The 4-bit output is just wide enough for the full -3 to +4 range, so any wrong sign handling in the third-order term shows up as an out-of-range or mismatched step.

// File: rtl/mash_pkg.sv
package mash_pkg;

    // Noise-shaping order codes, as seen on order_sel
    typedef enum logic [1:0] {
        ORD_OFF   = 2'd0,
        ORD_ONE   = 2'd1,
        ORD_TWO   = 2'd2,
        ORD_THREE = 2'd3
    } mash_order_e;

    localparam int MASH_STAGES = 3;

endpackage

// File: rtl/mash_accum.sv
// One modulo-2^W accumulator stage; residue and carry are this edge's results.
module mash_accum #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] addend,
    output logic [W-1:0] residue,
    output logic         carry
);

    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    assign sum     = {1'b0, acc_q} + {1'b0, addend};
    assign residue = sum[W-1:0];
    assign carry   = sum[W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= residue;
    end

endmodule

// File: rtl/mash_recomb.sv
// Delay-and-difference recombination of the stage carries, gated by order.
module mash_recomb
    import mash_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  mash_order_e          order,
    input  logic [MASH_STAGES-1:0] cy,
    output logic signed [DW-1:0] dith
);

    logic c2_d1, c3_d1, c3_d2;
    logic signed [DW-1:0] b1, b2, p2, b3, p3, q3;
    logic signed [DW-1:0] term1, term2, term3, nxt;

    assign b1 = $signed({{(DW-1){1'b0}}, cy[0]});
    assign b2 = $signed({{(DW-1){1'b0}}, cy[1]});
    assign p2 = $signed({{(DW-1){1'b0}}, c2_d1});
    assign b3 = $signed({{(DW-1){1'b0}}, cy[2]});
    assign p3 = $signed({{(DW-1){1'b0}}, c3_d1});
    assign q3 = $signed({{(DW-1){1'b0}}, c3_d2});

    always_comb begin
        term1 = b1;
        term2 = b2 - p2;
        term3 = b3 - (p3 <<< 1) + q3;
        unique case (order)
            ORD_OFF:   nxt = '0;
            ORD_ONE:   nxt = term1;
            ORD_TWO:   nxt = term1 + term2;
            ORD_THREE: nxt = term1 + term2 + term3;
            default:   nxt = '0;
        endcase
    end

    // Carry delay lines run in every order
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
        end else begin
            c2_d1 <= cy[1];
            c3_d1 <= cy[2];
            c3_d2 <= c3_d1;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dith <= '0;
        else        dith <= nxt;
    end

endmodule

// File: rtl/mash_dither.sv
module mash_dither
    import mash_pkg::*;
#(
    parameter int ACC_W  = 5,
    parameter int DITH_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ACC_W-1:0]         frac_word,
    input  logic [1:0]               order_sel,
    output logic signed [DITH_W-1:0] dither_out
);

    logic [MASH_STAGES-1:0] carries;
    mash_order_e            order;

    assign order = mash_order_e'(order_sel);

    for (genvar g = 0; g < MASH_STAGES; g++) begin : stg
        logic [ACC_W-1:0] addend;
        logic [ACC_W-1:0] res;
        if (g == 0) begin : g_head
            assign addend = frac_word;
        end else begin : g_chain
            assign addend = stg[g-1].res;
        end
        mash_accum #(.W(ACC_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .addend  (addend),
            .residue (res),
            .carry   (carries[g])
        );
    end

    mash_recomb #(.DW(DITH_W)) u_recomb (
        .clk   (clk),
        .rst_n (rst_n),
        .order (order),
        .cy    (carries),
        .dith  (dither_out)
    );

endmodule

// File: rtl/mash_dither_chk.sv
module mash_dither_chk #(
    parameter int DW = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           order_sel,
    input logic signed [DW-1:0] dither_out
);

    // R3
    order_off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (order_sel == 2'd0) |=> (dither_out == '0));

    // R2
    order_one_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (order_sel == 2'd1) |=> (dither_out == 0 || dither_out == 1));

    // R7
    order_two_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (order_sel == 2'd2) |=> (dither_out >= -1 && dither_out <= 2));

    // R4
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dither_out >= -3 && dither_out <= 4));

endmodule

bind mash_dither mash_dither_chk #(.DW(DITH_W)) u_mash_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .order_sel  (order_sel),
    .dither_out (dither_out)
);

// File: tb/test_mash_dither.sv
`timescale 1ns/1ps
module test_mash_dither;

    localparam int W  = 5;
    localparam int MOD = 32;
    localparam int NV = 8;
    // {order, frac, cycles, sum_lo, sum_hi}
    localparam int VEC [NV][5] = '{
        '{1, 16,  64, 32, 32},
        '{1,  5,  64, 10, 10},
        '{2,  5,  64, 10, 11},
        '{3,  5,  64,  9, 12},
        '{3, 31,  96, 92, 95},
        '{0, 17,  32,  0,  0},
        '{2,  0,  32,  0,  0},
        '{3,  1, 128,  3,  6}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [W-1:0]     frac_word = '0;
    logic [1:0]       order_sel = 2'd0;
    logic signed [3:0] dither_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 1'b0;

    // bench model state
    int a1, a2, a3, p2, p3, q3, exp_out;

    always #10 clk = ~clk;

    mash_dither i_mash_dither (
        .clk        (clk),
        .rst_n      (rst_n),
        .frac_word  (frac_word),
        .order_sel  (order_sel),
        .dither_out (dither_out)
    );

    task automatic check(input string req, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic model_reset();
        a1 = 0; a2 = 0; a3 = 0; p2 = 0; p3 = 0; q3 = 0; exp_out = 0;
    endtask

    // one rising edge of the model, per R8
    task automatic model_step(input int fr, input int ord);
        int c1, c2, c3;
        a1 = a1 + fr;  c1 = (a1 >= MOD) ? 1 : 0; a1 = a1 % MOD;
        a2 = a2 + a1;  c2 = (a2 >= MOD) ? 1 : 0; a2 = a2 % MOD;
        a3 = a3 + a2;  c3 = (a3 >= MOD) ? 1 : 0; a3 = a3 % MOD;
        if (ord == 0) exp_out = 0;
        else begin
            exp_out = c1;
            if (ord >= 2) exp_out += c2 - p2;
            if (ord == 3) exp_out += c3 - 2 * p3 + q3;
        end
        q3 = p3; p3 = c3; p2 = c2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        frac_word = '0;
        order_sel = 2'd0;
        repeat (2) @(negedge clk);
        check("R1 out during reset", int'(dither_out), 0);
        rst_n = 1'b1;
        model_reset();
        #1;
        check("R1 out after release", int'(dither_out), 0);
    endtask

    // drive at negedge, step the model, sample at next negedge
    task automatic cycle(input int fr, input int ord, input string req, output int got);
        frac_word = W'(fr);
        order_sel = 2'(ord);
        model_step(fr, ord);
        @(negedge clk);
        got = int'(dither_out);
        check(req, got, exp_out);
    endtask

    initial begin
        int got;
        int sum;
        do_reset();

        // table walk: model compare each cycle plus window sum
        for (int v = 0; v < NV; v++) begin
            do_reset();
            sum = 0;
            for (int c = 0; c < VEC[v][2]; c++) begin
                cycle(VEC[v][1], VEC[v][0], "R8 step vs model", got);
                sum += got;
            end
            n_tests++;
            if (sum < VEC[v][3] || sum > VEC[v][4]) begin
                n_fail++;
                $display("FAIL R5 window sum (vec %0d): actual %0d expected %0d..%0d",
                         v, sum, VEC[v][3], VEC[v][4]);
            end
        end

        // R2: hand sequence with frac 16, order 1
        do_reset();
        for (int c = 0; c < 6; c++) begin
            cycle(16, 1, "R2 model", got);
            check("R2 alternating carry", got, c % 2);
        end

        // R6: zero word gives zero in all orders
        for (int o = 0; o < 4; o++) begin
            do_reset();
            for (int c = 0; c < 40; c++) begin
                cycle(0, o, "R6 model", got);
                check("R6 zero word", got, 0);
            end
        end

        // R3 and R9: order switch mid-run takes effect after next edge
        do_reset();
        for (int c = 0; c < 10; c++) cycle(11, 3, "R9 warmup", got);
        cycle(11, 0, "R3 switch to off", got);
        check("R3 off after switch", got, 0);
        for (int c = 0; c < 5; c++) cycle(23, 0, "R3 off", got);
        for (int c = 0; c < 12; c++) cycle(23, 3, "R9 back to order 3", got);

        // R9: frac_word changing every cycle, order 2 then 3
        do_reset();
        for (int c = 0; c < 40; c++) cycle((c * 7 + 3) % MOD, 2, "R9 varying word", got);
        for (int c = 0; c < 40; c++) cycle((c * 13 + 1) % MOD, 3, "R9 varying word", got);

        // R4: extreme word at order 3, explicit range check
        do_reset();
        for (int c = 0; c < 64; c++) begin
            cycle(31, 3, "R4 model", got);
            n_tests++;
            if (got < -3 || got > 4) begin
                n_fail++;
                $display("FAIL R4 range: actual %0d expected -3..4", got);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule